// File: doc/BRIEF.md
# Banked Scratchpad Arbiter with SECDED

This block is the front end of a shared scratchpad memory built from independent banks that work in parallel. Twenty requesters reach it: sixteen compute cores, a management core, two network-on-chip DMA channels and a debug unit. The cores are folded pairwise into eight master ports by small pre-arbiters. Together with the four remaining requesters this gives twelve master ports. Each bank arbitrates among those twelve ports with its own rotating priority.

Words are 64 bits wide and are stored with eight SECDED check bits. A read returns corrected data, or flags an error it cannot correct. A write with a partial byte mask is a read-modify-write that keeps its bank busy for a second cycle. Each requester uses a valid/ready handshake. A 72-bit fault mask input is XORed into every codeword as it is written, so that memory faults can be reproduced.

Top module: `smem_top`

## Requirements
- R1: The low BANK_BITS bits of a word address select the bank and the upper bits select the row. Requests to different banks are accepted in the same cycle.
- R2: Each bank grants at most one of its twelve ports per cycle. The search starts at the port after the one granted last. When all ports contend steadily, grants follow port order 0..11 cyclically, and no port waits more than 12 cycles.
- R3: The two cores of a pair (requesters 2p and 2p+1 on port p) alternate when both request. A lone requesting core is presented at once.
- R4: A request is accepted in the cycle where req_ready_o and req_valid_i are both high. An unaccepted request is held and is served in a later cycle. req_ready_o is never high without req_valid_i.
- R5: Read data appears on rsp_rdata_o with rsp_valid_o one cycle after acceptance, and only for accepted reads.
- R6: A write with byte mask 8'hFF is stored in its acceptance cycle. A later read returns that word.
- R7: A write with any other mask merges its enabled bytes (bit j selects bits 8j+7..8j) into the corrected stored word. Its bank grants nothing in the following cycle.
- R8: Codeword bit 0 is overall parity. Check bits sit at positions 1,2,4,...,64, and data bits fill the other positions in ascending order (data bit 0 at position 3, data bit 1 at position 5). A single flipped codeword bit is corrected, with rsp_corr_o high.
- R9: Two flipped bits raise rsp_uncorr_o and return the uncorrected data bits. rsp_corr_o and rsp_uncorr_o are never both high.
- R10: During and right after reset no response is valid and no ready is raised.
- R11: Ports 8, 9, 10 and 11 carry requesters 16 (management), 17 and 18 (network DMA) and 19 (debug). After reset the lowest-numbered contending port of a bank wins first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 20 | Request valid per requester |
| req_we_i | input | 20 | Write when high, read when low |
| req_be_i | input | 20x8 | Byte enables for writes |
| req_addr_i | input | 20x8 | Word address (bank in low bits) |
| req_wdata_i | input | 20x64 | Write data |
| err_inject_i | input | 72 | Mask XORed into each written codeword |
| req_ready_o | output | 20 | Request accepted this cycle |
| rsp_valid_o | output | 20 | Read data valid |
| rsp_rdata_o | output | 20x64 | Read data |
| rsp_corr_o | output | 20 | Single-bit error corrected |
| rsp_uncorr_o | output | 20 | Uncorrectable error detected |

## Verification
Single requesters run a vector table of full and partial writes across several banks and rows, each read back by another requester. This separates byte merging from whole-word storage and bank decode. Concurrency patterns are tried separately: two requesters on different banks, which must both be accepted in one cycle; all twelve ports on one bank, which exposes the rotation order and the wait bound; and two cores of one pair, which exposes alternation. Faults are injected on one data bit, one check bit and two data bits, which separates correction from detection. A partial write to a corrupted word shows that the merge scrubs the error.

// File: rtl/smem_pkg.sv
`timescale 1ns/1ps
package smem_pkg;
  localparam int DW       = 64;
  localparam int CW       = 72;
  localparam int PBITS    = 7;
  localparam int NPORT    = 12;
  localparam int NPAIR    = 8;
  localparam int NREQ     = 2 * NPAIR + NPORT - NPAIR;
  localparam int RID_W    = $clog2(NREQ);

  typedef struct packed {
    logic [DW-1:0] data;
    logic          corr;
    logic          uncorr;
  } ecc_res_t;

  function automatic logic is_pow2(input int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  function automatic logic [PBITS-1:0] ecc_syn(input logic [CW-1:0] cw);
    logic [PBITS-1:0] s;
    s = '0;
    for (int pos = 1; pos < CW; pos++)
      if (cw[pos]) s = s ^ PBITS'(pos);
    return s;
  endfunction

  function automatic logic [DW-1:0] ecc_data(input logic [CW-1:0] cw);
    logic [DW-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int pos = 1; pos < CW; pos++)
      if (!is_pow2(pos)) begin
        d[k] = cw[pos];
        k++;
      end
    return d;
  endfunction

  function automatic logic [CW-1:0] ecc_enc(input logic [DW-1:0] d);
    logic [CW-1:0] cw;
    logic [PBITS-1:0] s;
    int k;
    cw = '0;
    k = 0;
    for (int pos = 1; pos < CW; pos++)
      if (!is_pow2(pos)) begin
        cw[pos] = d[k];
        k++;
      end
    s = ecc_syn(cw);
    for (int i = 0; i < PBITS; i++) cw[1 << i] = s[i];
    cw[0] = ^cw;
    return cw;
  endfunction

  function automatic ecc_res_t ecc_dec(input logic [CW-1:0] cw);
    ecc_res_t r;
    logic [PBITS-1:0] s;
    s = ecc_syn(cw);
    r.corr   = 1'b0;
    r.uncorr = 1'b0;
    r.data   = ecc_data(cw);
    if (^cw) begin
      if (int'(s) < CW) begin
        r.data = ecc_data(cw ^ (CW'(1) << s));
        r.corr = 1'b1;
      end else begin
        r.uncorr = 1'b1;
      end
    end else if (s != '0) begin
      r.uncorr = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/smem_rr_arb.sv
`timescale 1ns/1ps
module smem_rr_arb #(
  parameter  int N  = 12,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          en_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] last_q;
  logic          found;
  int            cand;

  // search starts one past the last winner
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    cand  = 0;
    for (int i = 0; i < N; i++) begin
      cand = (int'(last_q) + 1 + i) % N;
      if (!found && en_i && req_i[cand]) begin
        found        = 1'b1;
        gnt_o[cand]  = 1'b1;
        idx_o        = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= IW'(N - 1);
    else if (found)  last_q <= idx_o;
  end

  assert_gnt_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_gnt_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/smem_pair_arb.sv
`timescale 1ns/1ps
module smem_pair_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  input  logic       port_gnt_i,
  output logic       sel_o
);
  logic pref_q;

  assign sel_o = (req_i == 2'b11) ? pref_q : req_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pref_q <= 1'b0;
    else if (port_gnt_i) pref_q <= ~sel_o;
  end

  assert_pair_alternates_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 2'b11 && port_gnt_i && $past(req_i == 2'b11 && port_gnt_i))
      |-> sel_o != $past(sel_o));
endmodule

// File: rtl/smem_bank.sv
`timescale 1ns/1ps
module smem_bank
  import smem_pkg::*;
#(
  parameter  int ROW_BITS = 4,
  localparam int ROWS     = 1 << ROW_BITS,
  localparam int IW       = $clog2(NPORT)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NPORT-1:0]                   req_i,
  input  logic [NPORT-1:0][ROW_BITS-1:0]     row_i,
  input  logic [NPORT-1:0]                   we_i,
  input  logic [NPORT-1:0][7:0]              be_i,
  input  logic [NPORT-1:0][DW-1:0]           wdata_i,
  input  logic [NPORT-1:0][RID_W-1:0]        rid_i,
  input  logic [CW-1:0]                      inj_i,
  output logic [NPORT-1:0]                   gnt_o,
  output logic                               rsp_valid_o,
  output logic [RID_W-1:0]                   rsp_rid_o,
  output logic [DW-1:0]                      rsp_data_o,
  output logic                               rsp_corr_o,
  output logic                               rsp_uncorr_o
);
  logic [CW-1:0]       mem_q [ROWS];
  logic [IW-1:0]       gidx;
  logic                hit, rd, full_wr, part_wr;
  logic                rmw_q;
  logic [ROW_BITS-1:0] rmw_row_q, cur_row;
  logic [DW-1:0]       rmw_data_q, merged, cur_wdata;
  logic [7:0]          cur_be;
  ecc_res_t            old;

  smem_rr_arb #(.N(NPORT)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .en_i  (!rmw_q),
    .gnt_o (gnt_o),
    .idx_o (gidx)
  );

  assign hit       = |gnt_o;
  assign cur_row   = row_i[gidx];
  assign cur_be    = be_i[gidx];
  assign cur_wdata = wdata_i[gidx];
  assign rd        = hit && !we_i[gidx];
  assign full_wr   = hit && we_i[gidx] && (&cur_be);
  assign part_wr   = hit && we_i[gidx] && !(&cur_be);

  always_comb begin
    old = ecc_dec(mem_q[cur_row]);
    for (int j = 0; j < 8; j++)
      merged[8*j +: 8] = cur_be[j] ? cur_wdata[8*j +: 8] : old.data[8*j +: 8];
  end

  // encode of merged word deferred to the second cycle
  always_ff @(posedge clk_i) begin
    if (rmw_q)        mem_q[rmw_row_q] <= ecc_enc(rmw_data_q) ^ inj_i;
    else if (full_wr) mem_q[cur_row]   <= ecc_enc(cur_wdata) ^ inj_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rmw_q        <= 1'b0;
      rmw_row_q    <= '0;
      rmw_data_q   <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_rid_o    <= '0;
      rsp_data_o   <= '0;
      rsp_corr_o   <= 1'b0;
      rsp_uncorr_o <= 1'b0;
    end else begin
      rmw_q       <= part_wr;
      rsp_valid_o <= rd;
      if (part_wr) begin
        rmw_row_q  <= cur_row;
        rmw_data_q <= merged;
      end
      if (rd) begin
        rsp_rid_o    <= rid_i[gidx];
        rsp_data_o   <= old.data;
        rsp_corr_o   <= old.corr;
        rsp_uncorr_o <= old.uncorr;
      end
    end
  end

  assert_rmw_stalls_bank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(part_wr) |-> gnt_o == '0);
  assert_rsp_only_after_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(hit && !we_i[gidx]));
endmodule

// File: rtl/smem_top.sv
`timescale 1ns/1ps
module smem_top
  import smem_pkg::*;
#(
  parameter  int BANK_BITS = 4,
  parameter  int ROW_BITS  = 4,
  localparam int NBANK     = 1 << BANK_BITS,
  localparam int AW        = BANK_BITS + ROW_BITS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NREQ-1:0]            req_valid_i,
  input  logic [NREQ-1:0]            req_we_i,
  input  logic [NREQ-1:0][7:0]       req_be_i,
  input  logic [NREQ-1:0][AW-1:0]    req_addr_i,
  input  logic [NREQ-1:0][DW-1:0]    req_wdata_i,
  input  logic [CW-1:0]              err_inject_i,
  output logic [NREQ-1:0]            req_ready_o,
  output logic [NREQ-1:0]            rsp_valid_o,
  output logic [NREQ-1:0][DW-1:0]    rsp_rdata_o,
  output logic [NREQ-1:0]            rsp_corr_o,
  output logic [NREQ-1:0]            rsp_uncorr_o
);
  logic [NPAIR-1:0]                pair_sel;
  logic [NPORT-1:0]                port_valid, port_we, port_gnt;
  logic [NPORT-1:0][AW-1:0]        port_addr;
  logic [NPORT-1:0][ROW_BITS-1:0]  port_row;
  logic [NPORT-1:0][7:0]           port_be;
  logic [NPORT-1:0][DW-1:0]        port_wdata;
  logic [NPORT-1:0][RID_W-1:0]     port_rid;

  logic [NBANK-1:0][NPORT-1:0]     bank_req, bank_gnt;
  logic [NBANK-1:0]                bk_valid, bk_corr, bk_uncorr;
  logic [NBANK-1:0][RID_W-1:0]     bk_rid;
  logic [NBANK-1:0][DW-1:0]        bk_data;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    if (p < NPAIR) begin : g_pair
      smem_pair_arb u_pair (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req_valid_i[2*p +: 2]),
        .port_gnt_i(port_gnt[p]),
        .sel_o     (pair_sel[p])
      );
      assign port_valid[p] = |req_valid_i[2*p +: 2];
      assign port_we[p]    = pair_sel[p] ? req_we_i[2*p+1]    : req_we_i[2*p];
      assign port_addr[p]  = pair_sel[p] ? req_addr_i[2*p+1]  : req_addr_i[2*p];
      assign port_be[p]    = pair_sel[p] ? req_be_i[2*p+1]    : req_be_i[2*p];
      assign port_wdata[p] = pair_sel[p] ? req_wdata_i[2*p+1] : req_wdata_i[2*p];
      assign port_rid[p]   = RID_W'(2*p) + RID_W'(pair_sel[p]);
    end else begin : g_solo
      assign port_valid[p] = req_valid_i[p+NPAIR];
      assign port_we[p]    = req_we_i[p+NPAIR];
      assign port_addr[p]  = req_addr_i[p+NPAIR];
      assign port_be[p]    = req_be_i[p+NPAIR];
      assign port_wdata[p] = req_wdata_i[p+NPAIR];
      assign port_rid[p]   = RID_W'(p+NPAIR);
    end
    assign port_row[p] = port_addr[p][AW-1:BANK_BITS];
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_rdy
    if (r < 2*NPAIR) begin : g_core
      assign req_ready_o[r] = port_gnt[r/2] && (pair_sel[r/2] == 1'(r % 2));
    end else begin : g_other
      assign req_ready_o[r] = port_gnt[r-NPAIR];
    end
  end

  always_comb begin
    port_gnt = '0;
    for (int b = 0; b < NBANK; b++) begin
      for (int p = 0; p < NPORT; p++)
        bank_req[b][p] = port_valid[p] && (port_addr[p][BANK_BITS-1:0] == BANK_BITS'(b));
      port_gnt = port_gnt | bank_gnt[b];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    smem_bank #(.ROW_BITS(ROW_BITS)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (bank_req[b]),
      .row_i       (port_row),
      .we_i        (port_we),
      .be_i        (port_be),
      .wdata_i     (port_wdata),
      .rid_i       (port_rid),
      .inj_i       (err_inject_i),
      .gnt_o       (bank_gnt[b]),
      .rsp_valid_o (bk_valid[b]),
      .rsp_rid_o   (bk_rid[b]),
      .rsp_data_o  (bk_data[b]),
      .rsp_corr_o  (bk_corr[b]),
      .rsp_uncorr_o(bk_uncorr[b])
    );
  end

  // one grant per requester per cycle, so at most one bank answers each
  always_comb begin
    rsp_valid_o  = '0;
    rsp_rdata_o  = '0;
    rsp_corr_o   = '0;
    rsp_uncorr_o = '0;
    for (int b = 0; b < NBANK; b++)
      for (int r = 0; r < NREQ; r++)
        if (bk_valid[b] && bk_rid[b] == RID_W'(r)) begin
          rsp_valid_o[r]  = 1'b1;
          rsp_rdata_o[r]  = rsp_rdata_o[r] | bk_data[b];
          rsp_corr_o[r]   = bk_corr[b];
          rsp_uncorr_o[r] = bk_uncorr[b];
        end
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_chk
    assert_rsp_follows_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o[r] |-> $past(req_valid_i[r] && req_ready_o[r] && !req_we_i[r]));
    assert_flags_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rsp_corr_o[r] && rsp_uncorr_o[r]));
    assert_ready_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ready_o[r] |-> req_valid_i[r]);
  end
endmodule

// File: tb/smem_top_test.sv
`timescale 1ns/1ps
module smem_top_test;
  import smem_pkg::*;
  localparam int AW = 8;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [NREQ-1:0]         valid, we;
  logic [NREQ-1:0][7:0]    be;
  logic [NREQ-1:0][AW-1:0] addr;
  logic [NREQ-1:0][DW-1:0] wdata;
  logic [CW-1:0]           inj;
  logic [NREQ-1:0]         ready, rvalid, rcorr, runcorr;
  logic [NREQ-1:0][DW-1:0] rdata;

  int total = 0;
  int fails = 0;
  logic [DW-1:0] model [256];

  always #2 clk = ~clk;

  smem_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_we_i(we), .req_be_i(be), .req_addr_i(addr),
    .req_wdata_i(wdata), .err_inject_i(inj),
    .req_ready_o(ready), .rsp_valid_o(rvalid), .rsp_rdata_o(rdata),
    .rsp_corr_o(rcorr), .rsp_uncorr_o(runcorr)
  );

  // rid, addr, byte mask, data
  localparam logic [84:0] VEC [8] = '{
    {5'd0,  8'h00, 8'hFF, 64'h0123_4567_89AB_CDEF},
    {5'd5,  8'h01, 8'hFF, 64'hFEDC_BA98_7654_3210},
    {5'd16, 8'h00, 8'h0F, 64'h1111_1111_2222_2222},
    {5'd17, 8'h01, 8'h81, 64'hAAAA_AAAA_BBBB_BBBB},
    {5'd19, 8'h3F, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D},
    {5'd11, 8'h3F, 8'h3C, 64'h0000_0000_0000_0000},
    {5'd18, 8'hF0, 8'hFF, 64'h5A5A_5A5A_A5A5_A5A5},
    {5'd2,  8'hF0, 8'h01, 64'h0000_0000_0000_00FF}
  };

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n, input logic [7:0] m);
    logic [DW-1:0] r;
    for (int j = 0; j < 8; j++) r[8*j +: 8] = m[j] ? n[8*j +: 8] : o[8*j +: 8];
    return r;
  endfunction

  function automatic int req_of(input int p);
    return (p < NPAIR) ? 2 * p : p + NPAIR;
  endfunction

  task automatic access(input int rid, input logic [AW-1:0] a, input logic w, input logic [7:0] m,
                        input logic [DW-1:0] d, output logic [DW-1:0] q, output logic c, output logic u);
    @(negedge clk);
    valid[rid] = 1'b1; we[rid] = w; be[rid] = m; addr[rid] = a; wdata[rid] = d;
    #1;
    while (!ready[rid]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    valid[rid] = 1'b0;
    q = rdata[rid]; c = rcorr[rid]; u = runcorr[rid];
    if (!w) chk(rvalid[rid], "R5 rsp_valid", 64'(rvalid[rid]), 64'd1);
  endtask

  task automatic wr(input int rid, input logic [AW-1:0] a, input logic [7:0] m, input logic [DW-1:0] d);
    logic [DW-1:0] q; logic c, u;
    access(rid, a, 1'b1, m, d, q, c, u);
    model[a] = merge(model[a], d, m);
  endtask

  task automatic rd(input int rid, input logic [AW-1:0] a, output logic [DW-1:0] q, output logic c, output logic u);
    access(rid, a, 1'b0, 8'h00, '0, q, c, u);
  endtask

  initial begin
    #80000;
    total++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [DW-1:0] q; logic c, u;
    int prev, cnt, gp;
    int last_g [NPORT];
    int maxgap;
    valid = '0; we = '0; be = '0; addr = '0; wdata = '0; inj = '0;
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    chk(rvalid == '0 && ready == '0, "R10 in reset", 64'(rvalid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(rvalid == '0 && ready == '0, "R10 after reset", 64'(ready), 64'd0);

    // R11: after reset port 8 (req 16) beats port 11 (req 19) on bank 0
    @(negedge clk);
    valid[16] = 1; we[16] = 0; addr[16] = 8'h10;
    valid[19] = 1; we[19] = 0; addr[19] = 8'h20;
    #1;
    chk(ready[16] && !ready[19], "R11 lowest port first", 64'(ready), 64'h10000);
    @(negedge clk);
    valid[16] = 0;
    #1;
    chk(ready[19], "R4 held request served later", 64'(ready[19]), 64'd1);
    @(negedge clk);
    valid[19] = 0;

    // vector table: write, then read back from another requester
    for (int i = 0; i < 8; i++) begin
      int rid; logic [AW-1:0] a; logic [7:0] m; logic [DW-1:0] d;
      rid = int'(VEC[i][84:80]); a = VEC[i][79:72]; m = VEC[i][71:64]; d = VEC[i][63:0];
      wr(rid, a, m, d);
      rd((rid + 7) % NREQ, a, q, c, u);
      if (m == 8'hFF) chk(q == model[a] && !c && !u, "R6 full write readback", q, model[a]);
      else            chk(q == model[a] && !c && !u, "R7 merged readback", q, model[a]);
    end

    // R1: different banks accepted in one cycle
    @(negedge clk);
    valid[16] = 1; we[16] = 0; addr[16] = 8'h00;
    valid[17] = 1; we[17] = 0; addr[17] = 8'h01;
    #1;
    chk(ready[16] && ready[17], "R1 parallel banks", 64'(ready), 64'h30000);
    @(negedge clk);
    valid[16] = 0; valid[17] = 0;
    chk(rvalid[16] && rdata[16] == model[8'h00], "R1 bank0 data", rdata[16], model[8'h00]);
    chk(rvalid[17] && rdata[17] == model[8'h01], "R1 bank1 data", rdata[17], model[8'h01]);

    // R2: all twelve ports on bank 3
    @(negedge clk);
    for (int p = 0; p < NPORT; p++) begin
      valid[req_of(p)] = 1; we[req_of(p)] = 0; addr[req_of(p)] = 8'h03;
      last_g[p] = 0;
    end
    prev = -1; maxgap = 0;
    for (int cyc = 1; cyc <= 36; cyc++) begin
      #1;
      cnt = 0; gp = -1;
      for (int p = 0; p < NPORT; p++)
        if (ready[req_of(p)]) begin cnt++; gp = p; end
      chk(cnt == 1, "R2 one grant per bank", 64'(cnt), 64'd1);
      if (prev >= 0) chk(gp == (prev + 1) % NPORT, "R2 rotation order", 64'(gp), 64'((prev + 1) % NPORT));
      if (gp >= 0) begin
        if (cyc - last_g[gp] > maxgap) maxgap = cyc - last_g[gp];
        last_g[gp] = cyc;
      end
      prev = gp;
      @(negedge clk);
    end
    chk(maxgap <= NPORT, "R2 wait bound", 64'(maxgap), 64'(NPORT));
    valid = '0;

    // R3: pair 4/5 alternate, then a lone core
    @(negedge clk);
    valid[4] = 1; we[4] = 0; addr[4] = 8'h06;
    valid[5] = 1; we[5] = 0; addr[5] = 8'h16;
    prev = -1;
    for (int cyc = 0; cyc < 6; cyc++) begin
      #1;
      chk(ready[4] ^ ready[5], "R3 one core of pair", 64'(ready[5:4]), 64'd1);
      if (prev >= 0) chk(int'(ready[5]) != prev, "R3 alternation", 64'(ready[5]), 64'(prev == 0));
      prev = int'(ready[5]);
      @(negedge clk);
    end
    valid[4] = 0; valid[5] = 0;
    @(negedge clk);
    valid[7] = 1; we[7] = 0; addr[7] = 8'h07;
    #1;
    chk(ready[7], "R3 lone core immediate", 64'(ready[7]), 64'd1);
    @(negedge clk);
    valid[7] = 0;

    // R7: bank busy after partial write
    wr(16, 8'h05, 8'hFF, 64'h0706_0504_0302_0100);
    @(negedge clk);
    valid[16] = 1; we[16] = 1; be[16] = 8'hF0; addr[16] = 8'h05; wdata[16] = 64'hCCCC_CCCC_0000_0000;
    #1;
    chk(ready[16], "R7 partial write accepted", 64'(ready[16]), 64'd1);
    model[8'h05] = merge(model[8'h05], 64'hCCCC_CCCC_0000_0000, 8'hF0);
    @(negedge clk);
    valid[16] = 0;
    valid[17] = 1; we[17] = 0; addr[17] = 8'h15;
    #1;
    chk(!ready[17], "R7 bank stalled second cycle", 64'(ready[17]), 64'd0);
    @(negedge clk);
    #1;
    chk(ready[17], "R7 bank free again", 64'(ready[17]), 64'd1);
    @(negedge clk);
    valid[17] = 0;
    rd(18, 8'h05, q, c, u);
    chk(q == model[8'h05], "R7 merge result", q, model[8'h05]);

    // R8: single flips on a data bit and a check bit
    inj = 72'h8;
    wr(16, 8'h22, 8'hFF, 64'h1234_5678_9ABC_DEF0);
    inj = '0;
    rd(17, 8'h22, q, c, u);
    chk(q == model[8'h22] && c && !u, "R8 data bit corrected", q, model[8'h22]);
    inj = 72'h2;
    wr(16, 8'h23, 8'hFF, 64'h0F0F_0F0F_F0F0_F0F0);
    inj = '0;
    rd(17, 8'h23, q, c, u);
    chk(q == model[8'h23] && c && !u, "R8 check bit corrected", q, model[8'h23]);

    // R7 scrub: partial write over a corrupted word clears the error
    inj = 72'h8;
    wr(16, 8'h24, 8'hFF, 64'hAAAA_5555_AAAA_5555);
    inj = '0;
    wr(18, 8'h24, 8'h01, 64'h0000_0000_0000_0077);
    rd(17, 8'h24, q, c, u);
    chk(q == model[8'h24] && !c && !u, "R7 merge scrubs error", q, model[8'h24]);

    // R9: double flip on data bits 0 and 1
    inj = 72'h28;
    wr(16, 8'h25, 8'hFF, 64'h0000_0000_0000_1000);
    inj = '0;
    rd(17, 8'h25, q, c, u);
    chk(q == (model[8'h25] ^ 64'h3) && u && !c, "R9 raw data flagged", q, model[8'h25] ^ 64'h3);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule